// File: doc/BRIEF.md
# MFM Interval-Classifying Bit Decoder

This block turns a read signal recorded with Modified Frequency Modulation back into its plain data bits. The read line is brought into the 50 MHz clock domain, and each rising edge marks a flux transition. The block counts the clock cycles between two edges and sorts each gap into one of three classes. With nominal timing these are about 12 cycles (short), 18 cycles (long) and 24 cycles (very long). No sampling window or recovered clock is used.

A small decision engine decodes each classified gap. It holds a current-bit register and a phase register for runs of long gaps, and it produces one or two data bits per gap. These bits leave the block one per clock cycle on `bit_out`, each qualified by `bit_valid`. The first edge after reset only starts the timer. Each later edge ends one gap and starts the next.

Top module: `mfm_period_decoder`

## Requirements
- R1: After a synchronous reset, `bit_valid` is low. The current bit is 0 and the phase is 0. The first rising edge of `mfm_in` after reset produces no output bits.
- R2: The gap between two rising edges is measured in clock cycles. A gap of at most 12 cycles is short. A gap of 13 to 18 cycles is long. A gap of more than 18 cycles is very long.
- R3: A very-long gap emits the bit 1 and then the bit 0. It sets the phase to 0 and leaves the current bit unchanged.
- R4: A short gap emits the current bit once and sets the phase to 0.
- R5: A long gap in phase 0 or phase 1 first emits the current bit. When that bit is 0, a second 0 follows it. The gap then inverts the current bit and moves phase 0 to 1, or phase 1 to 2.
- R6: A long gap in phase 2 emits the current bit twice, inverts the current bit and sets the phase to 1.
- R7: Input edges are sampled on clock edges. Suppose `mfm_in` is first sampled high at clock edge n. The first decoded bit of the gap that this edge closes is valid after clock edge n+3. A second bit, if there is one, is valid after edge n+4.
- R8: The gap counter saturates at 2^CNT_W-1 (255 by default) instead of wrapping. A very long missing-transition gap therefore counts as very long.
- R9: After an arming edge, the gap sequence 12,12,18,12,12,12,18,12,18,18,18,12,12,24,24,24,24,12,12 decodes to 00001111000100111010101011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| mfm_in | input | 1 | Asynchronous MFM read line; a rising edge marks a transition |
| bit_out | output | 1 | Decoded data bit |
| bit_valid | output | 1 | High for one cycle for each decoded bit |

## Verification
The bench plays gaps that sit exactly on the class limits (11, 12, 13, 18, 19), so a comparison that is off by one moves a gap into the wrong class and changes the number of bits emitted. Runs of long gaps drive the phase register through 0, 1, 2, 1, 2. Some of these runs are broken by short or very-long gaps, so a design that fails to clear the phase, or that flips the current bit on a very-long gap, drifts out of step. A 260-cycle gap catches a counter that wraps, because the count would land at 4 and be read as short. A reset in the middle of a stream catches stale state, and the check that every bit arrives in its exact cycle catches a wrong pipeline depth and pairs of bits that are not sent back to back.

// File: rtl/mfm_dec_pkg.sv
package mfm_dec_pkg;

    typedef enum logic [1:0] {
        GAP_SHORT = 2'd0,
        GAP_LONG  = 2'd1,
        GAP_VLONG = 2'd2
    } gap_class_t;

endpackage

// File: rtl/mfm_edge_sync.sv
module mfm_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic rise_pulse
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic last;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = line_in;
        r_d.sync = r_q.meta;
        r_d.last = r_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rise_pulse = r_q.sync & ~r_q.last;

    AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse); // R7

endmodule

// File: rtl/mfm_gap_timer.sv
module mfm_gap_timer
    import mfm_dec_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SHORT_MAX = 12,
    parameter int LONG_MAX  = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_pulse,
    output logic       gap_vld,
    output gap_class_t gap_cls
);

    localparam logic [CNT_W-1:0] CNT_TOP   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_MAX);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             armed;
        logic             vld;
        gap_class_t       cls;
    } timer_regs_t;

    timer_regs_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.vld = 1'b0;
        if (rise_pulse) begin
            t_d.count = CNT_W'(1);
            t_d.armed = 1'b1;
            t_d.vld   = t_q.armed;
            if (t_q.count <= SHORT_LIM)     t_d.cls = GAP_SHORT;
            else if (t_q.count <= LONG_LIM) t_d.cls = GAP_LONG;
            else                            t_d.cls = GAP_VLONG;
        end else if (t_q.count != CNT_TOP) begin
            t_d.count = t_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '{count: '0, armed: 1'b0, vld: 1'b0, cls: GAP_SHORT};
        else     t_q <= t_d;
    end

    assign gap_vld = t_q.vld;
    assign gap_cls = t_q.cls;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (t_q.count == CNT_TOP && !rise_pulse) |=> t_q.count == CNT_TOP); // R8

    AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!t_q.armed && rise_pulse) |=> !gap_vld); // R1

    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        gap_vld |-> gap_cls != 2'd3); // R2

endmodule

// File: rtl/mfm_bit_engine.sv
module mfm_bit_engine
    import mfm_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gap_vld,
    input  gap_class_t gap_cls,
    output logic       bit_out,
    output logic       bit_valid
);

    typedef struct packed {
        logic       cur;
        logic [1:0] phase;
        logic       pend;
        logic       pend_bit;
        logic       obit;
        logic       ovld;
    } eng_regs_t;

    eng_regs_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.ovld = 1'b0;
        if (gap_vld) begin
            e_d.ovld = 1'b1;
            unique case (gap_cls)
                GAP_VLONG: begin
                    e_d.obit     = 1'b1;
                    e_d.pend     = 1'b1;
                    e_d.pend_bit = 1'b0;
                    e_d.phase    = 2'd0;
                end
                GAP_LONG: begin
                    e_d.obit = e_q.cur;
                    e_d.cur  = ~e_q.cur;
                    if (e_q.phase == 2'd2) begin
                        e_d.pend     = 1'b1;
                        e_d.pend_bit = e_q.cur;
                        e_d.phase    = 2'd1;
                    end else begin
                        e_d.pend     = ~e_q.cur;
                        e_d.pend_bit = 1'b0;
                        e_d.phase    = (e_q.phase == 2'd0) ? 2'd1 : 2'd2;
                    end
                end
                default: begin
                    e_d.obit  = e_q.cur;
                    e_d.pend  = 1'b0;
                    e_d.phase = 2'd0;
                end
            endcase
        end else if (e_q.pend) begin
            e_d.ovld = 1'b1;
            e_d.obit = e_q.pend_bit;
            e_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end

    assign bit_out   = e_q.obit;
    assign bit_valid = e_q.ovld;

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        e_q.phase != 2'd3); // R5

    AST_VLONG_ONE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (gap_vld && gap_cls == GAP_VLONG) |=> (bit_valid && bit_out)); // R3

    AST_VLONG_KEEPS_CUR: assert property (@(posedge clk) disable iff (rst)
        (gap_vld && gap_cls == GAP_VLONG) |=> e_q.cur == $past(e_q.cur)); // R3

    AST_SHORT_CLEARS_PHASE: assert property (@(posedge clk) disable iff (rst)
        (gap_vld && gap_cls == GAP_SHORT) |=> e_q.phase == 2'd0); // R4

    AST_LONG_FLIPS_CUR: assert property (@(posedge clk) disable iff (rst)
        (gap_vld && gap_cls == GAP_LONG) |=> e_q.cur != $past(e_q.cur)); // R5

    AST_PHASE2_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (gap_vld && gap_cls == GAP_LONG && e_q.phase == 2'd2) |=> e_q.phase == 2'd1); // R6

    AST_PAIR_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && e_q.pend) |=> bit_valid); // R7

endmodule

// File: rtl/mfm_period_decoder.sv
module mfm_period_decoder #(
    parameter int CNT_W     = 8,
    parameter int SHORT_MAX = 12,
    parameter int LONG_MAX  = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic mfm_in,
    output logic bit_out,
    output logic bit_valid
);

    import mfm_dec_pkg::*;

    logic       rise_pulse;
    logic       gap_vld;
    gap_class_t gap_cls;

    mfm_edge_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .line_in    (mfm_in),
        .rise_pulse (rise_pulse)
    );

    mfm_gap_timer #(
        .CNT_W     (CNT_W),
        .SHORT_MAX (SHORT_MAX),
        .LONG_MAX  (LONG_MAX)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .rise_pulse (rise_pulse),
        .gap_vld    (gap_vld),
        .gap_cls    (gap_cls)
    );

    mfm_bit_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .gap_vld   (gap_vld),
        .gap_cls   (gap_cls),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !bit_valid); // R1

endmodule

// File: tb/mfm_period_decoder_tb.sv
module mfm_period_decoder_tb;

    localparam int CLK_PERIOD = 20;
    localparam int SAT_MAX    = 255;

    typedef struct {
        int c;
        bit b;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mfm_in = 1'b0;
    logic bit_out;
    logic bit_valid;

    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string got = "";
    string ctx = "R1";

    int m_cur, m_ph, last_k;
    bit m_armed;

    mfm_period_decoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .mfm_in    (mfm_in),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push_bit(int c, bit b);
        exp_t e;
        e.c = c;
        e.b = b;
        exp_q.push_back(e);
    endfunction

    // reference: classify gap (R2, R8) then decode (R3..R6) with timing R7
    function automatic void model_edge(int k);
        int g;
        if (m_armed) begin
            g = k - last_k;
            if (g > SAT_MAX) g = SAT_MAX;
            if (g <= 12) begin
                push_bit(k + 4, bit'(m_cur));
                m_ph = 0;
            end else if (g <= 18) begin
                if (m_ph == 2) begin
                    push_bit(k + 4, bit'(m_cur));
                    push_bit(k + 5, bit'(m_cur));
                    m_ph = 1;
                end else begin
                    push_bit(k + 4, bit'(m_cur));
                    if (m_cur == 0) push_bit(k + 5, 1'b0);
                    m_ph = m_ph + 1;
                end
                m_cur = 1 - m_cur;
            end else begin
                push_bit(k + 4, 1'b1);
                push_bit(k + 5, 1'b0);
                m_ph = 0;
            end
        end
        m_armed = 1'b1;
        last_k  = k;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                got = {got, bit_out ? "1" : "0"};
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected bit %0d at cycle %0d, expected none", ctx, bit_out, cyc);
                end else begin
                    if (exp_q[0].c != cyc || exp_q[0].b != bit_out) begin
                        errors++;
                        $display("FAIL %s/R7: bit %0d at cycle %0d, expected %0d at cycle %0d",
                                 ctx, bit_out, cyc, exp_q[0].b, exp_q[0].c);
                    end
                    void'(exp_q.pop_front());
                end
            end else if (exp_q.size() != 0 && exp_q[0].c <= cyc) begin
                checks++;
                errors++;
                $display("FAIL %s/R7: no bit at cycle %0d, expected %0d", ctx, cyc, exp_q[0].b);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mfm_in = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (bit_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: bit_valid=%0b during reset, expected 0", bit_valid);
        end
        exp_q.delete();
        m_cur = 0; m_ph = 0; m_armed = 1'b0; last_k = 0;
        rst = 1'b0;
    endtask

    task automatic edge_after(int n);
        @(negedge clk);
        mfm_in = 1'b0;
        repeat (n - 1) @(negedge clk);
        mfm_in = 1'b1;
        model_edge(cyc);
    endtask

    task automatic play(input int gaps[$], input string want, input string tag);
        ctx = tag;
        got = "";
        edge_after(20);
        foreach (gaps[i]) edge_after(gaps[i]);
        @(negedge clk);
        mfm_in = 1'b0;
        repeat (12) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d bits missing, expected 0", tag, exp_q.size());
        end
        if (want != "") begin
            checks++;
            if (got != want) begin
                errors++;
                $display("FAIL %s: decoded %s, expected %s", tag, got, want);
            end
        end
    endtask

    initial begin
        int n_before;
        do_reset();
        // R1: arming edge alone produces nothing
        ctx = "R1";
        n_before = checks;
        edge_after(30);
        repeat (15) @(negedge clk);
        checks++;
        if (checks - 1 != n_before) begin
            errors++;
            $display("FAIL R1: %0d bits after first edge, expected 0", checks - 1 - n_before);
        end
        do_reset();
        play('{12,12,18,12,12,12,18,12,18,18,18,12,12,24,24,24,24,12,12},
             "00001111000100111010101011", "R9");
        do_reset();
        play('{12,12,18,12,18,18,12,18,18,12,18,18,12,18,18,12,18,18,12},
             "0000110011001100110011001", "R5");
        do_reset();
        play('{12,12,18,24,24,24,24,24,12,12,12}, "00001010101010111", "R3");
        do_reset();
        play('{12,12,18,18,18,18,18,18,18,18,18,12,18,18,18}, "", "R6");
        do_reset();
        play('{11,12,13,18,19,12,13,13,13,11,19,13,24,17}, "", "R2");
        do_reset();
        play('{18,18,12,18,18,18,24,18,12,12,18}, "", "R4");
        do_reset();
        play('{18,260,12,18,300,18}, "", "R8");
        // mid-stream reset must clear current bit and phase (R1)
        do_reset();
        ctx = "R1";
        edge_after(20); edge_after(18); edge_after(18);
        repeat (10) @(negedge clk);
        do_reset();
        play('{12,18,12}, "0001", "R1");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule